// File: doc/BRIEF.md
# Programmable Asynchronous Serial Channel

This block is a full-duplex asynchronous serial channel. A transmitter takes a byte from a one-entry holding register and shifts it onto the line. It adds a low start bit, the data bits least significant first, an optional parity bit and a high stop period. A receiver watches the incoming line, finds start bits, samples each bit near its centre and rebuilds the character. Each received character comes with its own parity-error and framing-error flags. An overrun flag reports that a character was lost.

The character format is set by static inputs: a length code, a parity enable and type, and a stop-length code. Each side takes its copy of the format when a character starts, so a change to the format never corrupts a character already in flight. Timing comes from a single-cycle enable, `tick_i`, that pulses sixteen times per bit period. An optional auto-enable mode lets the active-low clear-to-send input gate the transmitter and the active-low carrier-detect input gate the receiver. Whatever the mode, both inputs are reported on registered status outputs.

Top module: `serial_chan`

## Requirements
- R1: The length code selects 00 = 5, 01 = 7, 10 = 6 and 11 = 8 data bits for both directions. Bits above the selected length are not sent, and they read as zero in `rx_data_o`.
- R2: The line idles high. A transmitted character is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. Each bit lasts 16 ticks.
- R3: With `par_en_i` set, the parity bit makes the count of ones among the data and parity bits even when `par_even_i` is 1, and odd when it is 0. The receiver sets `par_err_o` for a character whose parity bit disagrees. With parity off, `par_err_o` is 0.
- R4: The stop code selects 01 = 1 stop bit (16 ticks), 10 = 1.5 stop bits (24 ticks) and 11 = 2 stop bits (32 ticks). Code 00 means no asynchronous framing: no character is sent and no start bit is detected.
- R5: `tx_load_i` writes the holding register only while `tx_empty_o` is 1, and `tx_empty_o` then drops. The holding register moves into the shifter when the shifter is idle and the transmitter is enabled, and `tx_empty_o` rises in that cycle. A load while `tx_empty_o` is 0 is ignored.
- R6: The receiver checks a detected start bit 8 ticks after detection and abandons it if the line is high again. Data, parity and stop bits are sampled every 16 ticks after that point.
- R7: A stop bit sampled low sets `frm_err_o` for that character.
- R8: If a character completes while `rx_avail_o` is 1 and no read is given in that cycle, `ovr_err_o` is set and the new character replaces the old one. `rx_read_i` clears `rx_avail_o` and `ovr_err_o`.
- R9: With `auto_en_i` set, a character starts to transmit only while `cts_n_i` is low, and a start bit is detected only while `dcd_n_i` is low. Without it, both inputs have no effect on data flow.
- R10: `cts_o` and `dcd_o` equal the inverted `cts_n_i` and `dcd_n_i` one clock later, in every mode.
- R11: While `rx_en_i` is 0 the receiver ignores the line. While `tx_en_i` is 0 no new character starts.
- R12: After reset `txd_o` is 1, `tx_empty_o` is 1, and `rx_avail_o` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_code_i | input | 2 | Character length code |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop_code_i | input | 2 | Stop length code, 00 = framing off |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| auto_en_i | input | 1 | Gate the sides by clear-to-send and carrier-detect |
| cts_n_i | input | 1 | Clear-to-send, active low |
| dcd_n_i | input | 1 | Carrier-detect, active low |
| cts_o | output | 1 | Registered clear-to-send status |
| dcd_o | output | 1 | Registered carrier-detect status |
| tx_data_i | input | 8 | Byte to send, right-justified |
| tx_load_i | input | 1 | Write strobe for the holding register |
| tx_empty_o | output | 1 | Holding register free |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| rx_read_i | input | 1 | Acknowledge of the received character |
| rx_data_o | output | 8 | Received character, right-justified |
| rx_avail_o | output | 1 | Received character waiting |
| par_err_o | output | 1 | Parity error of the held character |
| frm_err_o | output | 1 | Framing error of the held character |
| ovr_err_o | output | 1 | A character was overwritten before being read |

## Verification
Results fall due at three distances. Status outputs and `tx_empty_o` settle one clock after their cause, and the bench reads them at the next falling edge. Serial bits are counted in ticks the design has consumed, so the bench samples the transmit line 8 ticks into a bit and drives receive bits on tick boundaries, each held 16 ticks. A received character is due at the middle of its stop bit plus two synchronizer clocks, so the bench reads the receive flags only after it has finished driving the whole stop period. The stop length is measured as the tick distance from the middle of the last bit to the next start edge, with a window of two ticks on either side.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

  // non-monotonic length code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b01:   return 4'd7;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] code);
    return CHAR_W'((9'd1 << char_bits(code)) - 9'd1);
  endfunction

  function automatic logic par_bit(input logic [CHAR_W-1:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  // data shifted in from the top ends left-justified
  function automatic logic [CHAR_W-1:0] justify(input logic [CHAR_W-1:0] s, input logic [3:0] n);
    return s >> (4'd8 - n);
  endfunction

endpackage

// File: rtl/serial_chan_tx.sv
module serial_chan_tx
  import serial_chan_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        len_code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [1:0]        stop_code_i,
  input  logic              go_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              load_i,
  output logic              empty_o,
  output logic              txd_o
);

  localparam int TICK_W = $clog2(2*OVERSAMPLE + 1);

  logic [CHAR_W-1:0] hold_q, sh_q;
  logic              empty_q, busy_q, txd_q, par_q, pen_q;
  phase_e            ph_q;
  logic [2:0]        bit_q;
  logic [3:0]        nb_q;
  logic [TICK_W-1:0] tcnt_q, stop_q, last_tick;
  logic              move, last_bit;
  logic [CHAR_W-1:0] masked;

  function automatic logic [TICK_W-1:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'b10:   return TICK_W'(OVERSAMPLE + OVERSAMPLE/2);
      2'b11:   return TICK_W'(2*OVERSAMPLE);
      default: return TICK_W'(OVERSAMPLE);
    endcase
  endfunction

  assign move      = !empty_q && !busy_q && go_i;
  assign masked    = hold_q & char_mask(len_code_i);
  assign last_tick = (ph_q == PH_STOP) ? stop_q - TICK_W'(1) : TICK_W'(OVERSAMPLE-1);
  assign last_bit  = ({1'b0, bit_q} == nb_q - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      sh_q    <= '0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      ph_q    <= PH_START;
      bit_q   <= '0;
      nb_q    <= 4'd8;
      tcnt_q  <= '0;
      stop_q  <= TICK_W'(OVERSAMPLE);
    end else begin
      if (load_i && empty_q) begin
        hold_q  <= data_i;
        empty_q <= 1'b0;
      end
      if (move) begin
        empty_q <= 1'b1;
        busy_q  <= 1'b1;
        ph_q    <= PH_START;
        sh_q    <= masked;
        par_q   <= par_bit(masked, par_even_i);
        pen_q   <= par_en_i;
        nb_q    <= char_bits(len_code_i);
        stop_q  <= stop_ticks(stop_code_i);
        bit_q   <= '0;
        tcnt_q  <= '0;
        txd_q   <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (tcnt_q == last_tick) begin
          tcnt_q <= '0;
          case (ph_q)
            PH_START: begin
              ph_q  <= PH_DATA;
              bit_q <= '0;
              txd_q <= sh_q[0];
              sh_q  <= sh_q >> 1;
            end
            PH_DATA: begin
              if (last_bit) begin
                ph_q  <= pen_q ? PH_PAR : PH_STOP;
                txd_q <= pen_q ? par_q : 1'b1;
              end else begin
                bit_q <= bit_q + 3'd1;
                txd_q <= sh_q[0];
                sh_q  <= sh_q >> 1;
              end
            end
            PH_PAR: begin
              ph_q  <= PH_STOP;
              txd_q <= 1'b1;
            end
            default: begin
              busy_q <= 1'b0;
              txd_q  <= 1'b1;
            end
          endcase
        end else begin
          tcnt_q <= tcnt_q + TICK_W'(1);
        end
      end
    end
  end

  assign empty_o = empty_q;
  assign txd_o   = txd_q;

endmodule

// File: rtl/serial_chan_rx.sv
module serial_chan_rx
  import serial_chan_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        len_code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              go_i,
  input  logic              rxd_i,
  input  logic              read_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              avail_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OVERSAMPLE - 1);

  logic rxd_s;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      end
      assign rxd_s = sync_q[SYNC_STAGES-1];
    end else begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b1;
        else         sync_q <= rxd_i;
      end
      assign rxd_s = sync_q;
    end
  endgenerate

  logic              act_q, pen_q, peven_q, perr_q;
  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [3:0]        nb_q;
  logic [CHAR_W-1:0] sh_q, data_q, dj;
  logic              avail_q, par_err_q, frm_err_q, ovr_q;
  logic              sample, done;

  assign dj     = justify(sh_q, nb_q);
  assign sample = act_q && tick_i && (ph_q != PH_START) && (cnt_q == FULL);
  assign done   = sample && (ph_q == PH_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      pen_q     <= 1'b0;
      peven_q   <= 1'b0;
      perr_q    <= 1'b0;
      ph_q      <= PH_START;
      cnt_q     <= '0;
      bit_q     <= '0;
      nb_q      <= 4'd8;
      sh_q      <= '0;
      data_q    <= '0;
      avail_q   <= 1'b0;
      par_err_q <= 1'b0;
      frm_err_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (read_i) begin
        avail_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (!act_q) begin
        if (tick_i && go_i && !rxd_s) begin
          act_q   <= 1'b1;
          ph_q    <= PH_START;
          cnt_q   <= '0;
          bit_q   <= '0;
          perr_q  <= 1'b0;
          pen_q   <= par_en_i;
          peven_q <= par_even_i;
          nb_q    <= char_bits(len_code_i);
        end
      end else if (tick_i) begin
        if (ph_q == PH_START) begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            if (rxd_s) act_q <= 1'b0;   // glitch
            else       ph_q  <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (cnt_q != FULL) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end else begin
          cnt_q <= '0;
          case (ph_q)
            PH_DATA: begin
              sh_q <= {rxd_s, sh_q[CHAR_W-1:1]};
              if ({1'b0, bit_q} == nb_q - 4'd1) ph_q <= pen_q ? PH_PAR : PH_STOP;
              else                              bit_q <= bit_q + 3'd1;
            end
            PH_PAR: begin
              perr_q <= (rxd_s != par_bit(dj, peven_q));
              ph_q   <= PH_STOP;
            end
            default: begin
              act_q     <= 1'b0;
              data_q    <= dj;
              avail_q   <= 1'b1;
              par_err_q <= perr_q & pen_q;
              frm_err_q <= !rxd_s;
              if (avail_q && !read_i) ovr_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign data_o    = data_q;
  assign avail_o   = avail_q;
  assign par_err_o = par_err_q;
  assign frm_err_o = frm_err_q;
  assign ovr_err_o = ovr_q;
  assign done_o    = done;

endmodule

// File: rtl/serial_chan.sv
module serial_chan
  import serial_chan_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        len_code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [1:0]        stop_code_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              auto_en_i,
  input  logic              cts_n_i,
  input  logic              dcd_n_i,
  output logic              cts_o,
  output logic              dcd_o,
  input  logic [CHAR_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_empty_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              rx_read_i,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              rx_avail_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);

  logic framing_on, tx_go, rx_go, rx_done;

  assign framing_on = (stop_code_i != 2'b00);
  assign tx_go = framing_on && tx_en_i && (!auto_en_i || !cts_n_i);
  assign rx_go = framing_on && rx_en_i && (!auto_en_i || !dcd_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_o <= 1'b0;
      dcd_o <= 1'b0;
    end else begin
      cts_o <= !cts_n_i;
      dcd_o <= !dcd_n_i;
    end
  end

  serial_chan_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .len_code_i (len_code_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .stop_code_i(stop_code_i),
    .go_i       (tx_go),
    .data_i     (tx_data_i),
    .load_i     (tx_load_i),
    .empty_o    (tx_empty_o),
    .txd_o      (txd_o)
  );

  serial_chan_rx #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .len_code_i (len_code_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .go_i       (rx_go),
    .rxd_i      (rxd_i),
    .read_i     (rx_read_i),
    .data_o     (rx_data_o),
    .avail_o    (rx_avail_o),
    .par_err_o  (par_err_o),
    .frm_err_o  (frm_err_o),
    .ovr_err_o  (ovr_err_o),
    .done_o     (rx_done)
  );

endmodule

// File: rtl/serial_chan_chk.sv
module serial_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] stop_code_i,
  input logic       tx_en_i,
  input logic       auto_en_i,
  input logic       cts_n_i,
  input logic       dcd_n_i,
  input logic       cts_o,
  input logic       dcd_o,
  input logic       tx_empty_o,
  input logic       txd_o,
  input logic       rx_read_i,
  input logic       rx_avail_o,
  input logic       ovr_err_o,
  input logic       rx_done_i
);

  // R2: a character leaves the holding register together with its start bit
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> !txd_o);

  // R4: no character starts with framing off
  p_no_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(stop_code_i) != 2'b00);

  // R9 / R11: transmit start needs enable and, in auto mode, clear-to-send
  p_tx_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(tx_en_i && (!auto_en_i || !cts_n_i)));

  // R8: overrun only on top of an unread character
  p_ovr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(rx_avail_o));

  // R8: a read with no new character clears both flags
  p_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_read_i && !rx_done_i) |=> (!rx_avail_o && !ovr_err_o));

  // R10: status follows the inverted inputs one clock later
  p_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cts_o == !$past(cts_n_i)) && (dcd_o == !$past(dcd_n_i)));

endmodule

bind serial_chan serial_chan_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_code_i(stop_code_i),
  .tx_en_i    (tx_en_i),
  .auto_en_i  (auto_en_i),
  .cts_n_i    (cts_n_i),
  .dcd_n_i    (dcd_n_i),
  .cts_o      (cts_o),
  .dcd_o      (dcd_o),
  .tx_empty_o (tx_empty_o),
  .txd_o      (txd_o),
  .rx_read_i  (rx_read_i),
  .rx_avail_o (rx_avail_o),
  .ovr_err_o  (ovr_err_o),
  .rx_done_i  (rx_done)
);

// File: tb/serial_chan_tb.sv
`timescale 1ns/1ps
module serial_chan_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] len_code = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0;
  logic [1:0] stop_code = 2'b01;
  logic       tx_en = 1'b1, rx_en = 1'b1, auto_en = 1'b0;
  logic       cts_n = 1'b1, dcd_n = 1'b1;
  logic       cts_s, dcd_s;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic       tx_empty, txd;
  logic       rxd_drv = 1'b1, loop_sel = 1'b0, rxd;
  logic       rx_read = 1'b0;
  logic [7:0] rx_data;
  logic       rx_avail, par_err, frm_err, ovr_err;

  int n_chk = 0, n_fail = 0;
  int ticks_done = 0;
  int tick_phase = 0;

  always #2.5 clk = ~clk;
  assign rxd = loop_sel ? txd : rxd_drv;

  serial_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .len_code_i(len_code), .par_en_i(par_en), .par_even_i(par_even),
    .stop_code_i(stop_code), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .auto_en_i(auto_en), .cts_n_i(cts_n), .dcd_n_i(dcd_n),
    .cts_o(cts_s), .dcd_o(dcd_s),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_empty_o(tx_empty), .txd_o(txd),
    .rxd_i(rxd), .rx_read_i(rx_read), .rx_data_o(rx_data), .rx_avail_o(rx_avail),
    .par_err_o(par_err), .frm_err_o(frm_err), .ovr_err_o(ovr_err)
  );

  // one tick every 4 clocks, driven at the falling edge
  initial forever begin
    @(negedge clk);
    tick_phase = (tick_phase + 1) % 4;
    tick = (tick_phase == 0);
  end

  always @(posedge clk) if (tick) ticks_done <= ticks_done + 1;

  function automatic int nbits(input logic [1:0] c);
    case (c)
      2'b00: return 5;
      2'b01: return 7;
      2'b10: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] mask(input logic [1:0] c);
    return 8'((9'd1 << nbits(c)) - 9'd1);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic even);
    int ones = $countones(d);
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  function automatic int stop_len(input logic [1:0] c);
    case (c)
      2'b10: return 24;
      2'b11: return 32;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int tgt = ticks_done + n;
    while (ticks_done < tgt) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic ev, input logic [1:0] s);
    @(negedge clk);
    len_code = l; par_en = pe; par_even = ev; stop_code = s;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  // capture one transmitted frame; gap = ticks from middle of last bit to next start
  task automatic capture(input int n, input bit pen, output logic [7:0] d, output logic p,
                         output int gap, output bit ok);
    int w = 0;
    int t0;
    d = '0; p = 1'b0; gap = -1; ok = 1'b1;
    while (txd === 1'b1 && w < 6000) begin @(negedge clk); w++; end
    if (w >= 6000) begin ok = 1'b0; return; end
    wait_ticks(8);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < n; i++) begin wait_ticks(16); d[i] = txd; end
    if (pen) begin wait_ticks(16); p = txd; end
    wait_ticks(10);
    if (txd !== 1'b1) ok = 1'b0;
    t0 = ticks_done - 10;
    while (txd !== 1'b0 && (ticks_done - t0) < 48) @(negedge clk);
    if (txd === 1'b0) gap = ticks_done - t0;
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit pen, input bit ev,
                            input bit bad_par, input bit bad_stop, input int idle);
    @(negedge clk);
    rxd_drv = 1'b0; wait_ticks(16);
    for (int i = 0; i < n; i++) begin rxd_drv = d[i]; wait_ticks(16); end
    if (pen) begin rxd_drv = exp_par(d & 8'((9'd1 << n) - 9'd1), ev) ^ bad_par; wait_ticks(16); end
    if (bad_stop) begin rxd_drv = 1'b0; wait_ticks(10); rxd_drv = 1'b1; wait_ticks(6); end
    else begin rxd_drv = 1'b1; wait_ticks(16); end
    wait_ticks(idle);
  endtask

  // directed transmit pair: first frame's gap measured, second frame followed by silence
  task automatic tx_pair(input logic [1:0] l, input logic pe, input logic ev, input logic [1:0] s,
                         input logic [7:0] a, input logic [7:0] b, input string req);
    logic [7:0] d; logic p; int gap; bit ok; int n;
    n = nbits(l);
    set_cfg(l, pe, ev, s);
    load(a);
    load(b);
    capture(n, pe, d, p, gap, ok);
    chk(ok, "R2", "frame shape A", ok, 1);
    chk(d == (a & mask(l)), req, "tx data A (R1)", d, a & mask(l));
    if (pe) chk(p == exp_par(a & mask(l), ev), "R3", "tx parity A", p, exp_par(a & mask(l), ev));
    chk(gap >= 8 + stop_len(s) - 2 && gap <= 8 + stop_len(s) + 2, "R4", "stop gap", gap, 8 + stop_len(s));
    capture(n, pe, d, p, gap, ok);
    chk(ok, "R2", "frame shape B", ok, 1);
    chk(d == (b & mask(l)), req, "tx data B (R1)", d, b & mask(l));
    chk(gap == -1, "R5", "line idle after B", gap, -1);
  endtask

  initial begin
    int w;
    bit ok, hi;
    logic [7:0] d, a, b; logic p; int gap;
    logic [1:0] l, s; logic pe, ev;

    void'($urandom(32'd61357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(txd == 1'b1 && tx_empty == 1'b1, "R12", "tx idle", {txd, tx_empty}, 3);
    chk({rx_avail, par_err, frm_err, ovr_err} == 4'b0, "R12", "rx flags",
        {rx_avail, par_err, frm_err, ovr_err}, 0);

    // R10 status follows inputs
    cts_n = 1'b0; @(negedge clk);
    chk(cts_s == 1'b1, "R10", "cts status", cts_s, 1);
    dcd_n = 1'b0; cts_n = 1'b1; @(negedge clk);
    chk(dcd_s == 1'b1 && cts_s == 1'b0, "R10", "dcd/cts status", {dcd_s, cts_s}, 2);
    cts_n = 1'b0;

    // R5 holding register handshake, load while full ignored
    set_cfg(2'b11, 1'b1, 1'b1, 2'b01);
    load(8'hA5);
    load(8'h3C);
    chk(tx_empty == 1'b0, "R5", "empty low with holding full", tx_empty, 0);
    load(8'hFF);
    capture(8, 1'b1, d, p, gap, ok);
    chk(ok && d == 8'hA5, "R2", "tx first byte", d, 8'hA5);
    chk(p == exp_par(8'hA5, 1'b1), "R3", "even parity", p, exp_par(8'hA5, 1'b1));
    chk(gap >= 22 && gap <= 26, "R4", "1 stop bit gap", gap, 24);
    capture(8, 1'b1, d, p, gap, ok);
    chk(ok && d == 8'h3C, "R5", "tx second byte", d, 8'h3C);
    chk(gap == -1, "R5", "ignored load not sent", gap, -1);

    // R1 length codes, R4 stop lengths
    tx_pair(2'b01, 1'b1, 1'b0, 2'b10, 8'hFF, 8'h2A, "R1");
    tx_pair(2'b10, 1'b0, 1'b0, 2'b11, 8'hC3, 8'h3F, "R1");
    tx_pair(2'b00, 1'b1, 1'b1, 2'b01, 8'hF5, 8'h0A, "R1");

    // R4 stop code 00 disables framing
    set_cfg(2'b11, 1'b0, 1'b0, 2'b00);
    load(8'h00);
    hi = 1'b1;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi && tx_empty == 1'b0, "R4", "no frame with code 00", {hi, tx_empty}, 2);
    set_cfg(2'b11, 1'b0, 1'b0, 2'b01);
    capture(8, 1'b0, d, p, gap, ok);
    chk(ok && d == 8'h00, "R4", "frame after framing on", d, 0);

    // R9 transmit auto-enable
    auto_en = 1'b1; cts_n = 1'b1;
    load(8'h42);
    hi = 1'b1;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi && tx_empty == 1'b0, "R9", "tx held without cts", {hi, tx_empty}, 2);
    @(negedge clk); cts_n = 1'b0;
    capture(8, 1'b0, d, p, gap, ok);
    chk(ok && d == 8'h42, "R9", "tx after cts", d, 8'h42);
    auto_en = 1'b0;

    // receive direction
    set_cfg(2'b11, 1'b1, 1'b1, 2'b01);
    send_frame(8'h5A, 8, 1, 1, 0, 0, 4);
    chk(rx_avail && rx_data == 8'h5A, "R2", "rx byte", rx_data, 8'h5A);
    chk(!par_err && !frm_err && !ovr_err, "R3", "rx clean flags", {par_err, frm_err, ovr_err}, 0);
    do_read();
    chk(!rx_avail, "R8", "read clears avail", rx_avail, 0);

    send_frame(8'h81, 8, 1, 1, 1, 0, 4);
    chk(rx_avail && par_err, "R3", "parity error flagged", par_err, 1);
    do_read();

    set_cfg(2'b11, 1'b0, 1'b0, 2'b01);
    send_frame(8'h66, 8, 0, 0, 0, 1, 20);
    chk(rx_avail && frm_err && rx_data == 8'h66, "R7", "framing error", {frm_err, rx_data}, 9'h166);
    do_read();

    set_cfg(2'b01, 1'b1, 1'b0, 2'b01);
    send_frame(8'hD5, 7, 1, 0, 0, 0, 4);
    chk(rx_avail && rx_data == 8'h55 && !par_err, "R1", "7-bit rx justified", rx_data, 8'h55);
    do_read();
    set_cfg(2'b10, 1'b0, 1'b0, 2'b01);
    send_frame(8'h2B, 6, 0, 0, 0, 0, 4);
    chk(rx_avail && rx_data == 8'h2B, "R1", "6-bit rx", rx_data, 8'h2B);
    do_read();

    // R6 glitch rejection
    @(negedge clk); rxd_drv = 1'b0; wait_ticks(3); rxd_drv = 1'b1; wait_ticks(40);
    chk(!rx_avail, "R6", "glitch rejected", rx_avail, 0);

    // R8 overrun
    set_cfg(2'b11, 1'b0, 1'b0, 2'b01);
    send_frame(8'h11, 8, 0, 0, 0, 0, 2);
    send_frame(8'h22, 8, 0, 0, 0, 0, 2);
    chk(rx_avail && ovr_err && rx_data == 8'h22, "R8", "overrun keeps newest", {ovr_err, rx_data}, 9'h122);
    do_read();
    chk(!rx_avail && !ovr_err, "R8", "read clears overrun", {rx_avail, ovr_err}, 0);

    // R11 receiver disabled
    rx_en = 1'b0;
    send_frame(8'h77, 8, 0, 0, 0, 0, 4);
    chk(!rx_avail, "R11", "rx disabled ignores line", rx_avail, 0);
    rx_en = 1'b1;

    // R9 receive auto-enable
    auto_en = 1'b1; dcd_n = 1'b1;
    send_frame(8'h99, 8, 0, 0, 0, 0, 4);
    chk(!rx_avail, "R9", "rx held without carrier", rx_avail, 0);
    dcd_n = 1'b0;
    send_frame(8'h99, 8, 0, 0, 0, 0, 4);
    chk(rx_avail && rx_data == 8'h99, "R9", "rx with carrier", rx_data, 8'h99);
    do_read();
    auto_en = 1'b0;

    // random loopback
    loop_sel = 1'b1;
    for (int k = 0; k < 24; k++) begin
      l = 2'($urandom); pe = 1'($urandom); ev = 1'($urandom);
      s = 2'($urandom_range(3, 1)); a = 8'($urandom);
      set_cfg(l, pe, ev, s);
      load(a);
      w = 0;
      while (!rx_avail && w < 3000) begin @(negedge clk); w++; end
      b = a & mask(l);
      chk(rx_avail && rx_data == b, "R1", "loopback data", rx_data, b);
      chk(!par_err && !frm_err && !ovr_err, "R3", "loopback flags", {par_err, frm_err, ovr_err}, 0);
      do_read();
      wait_ticks(40);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule